// File: doc/BRIEF.md
# Multichannel serial audio port

This block moves 20-bit audio samples between a fixed-point audio processor and the serial audio pins. Two receive ports each turn a left/right-clocked serial stream into one stereo sample pair. One transmit section turns six sample words into three stereo serial lines. All three lines share one bit clock and one frame clock, and that section generates both clocks from a 384fs master-clock enable. Receive port 1 can run as clock master, using the generated clocks and driving them onto its clock pins. It can also run as clock slave and follow its own clock pins. Receive port 2 always follows its own pins.

The frame format is fixed and uses one justification. The frame clock is low for the left channel. The MSB starts one bit period after each frame-clock edge. Data changes on the falling bit-clock edge and is sampled on the rising edge. The bit clock runs at 64fs (32 slots per channel) or 32fs (16 slots per channel). The word length is 16, 18 or 20 bits. Trailing slot bits are zero. Samples are kept left-aligned in the 20-bit words.

Both data directions use a valid/ready handshake. The transmit side takes a six-word set only while its holding register is empty. It moves that set into the serializer at the start of the next frame. The receive side cannot stall the serial line. A pair that has not been read is replaced by the next complete pair, and `rx_valid` stays high until `rx_ready` is seen.

Top module: `audio_serial_port`

## Requirements
- R1: While `rst_n` is low, `out_bck`, `out_lrck`, `out_sd`, `tx_load`, `rx_valid` and `rx_frame` are all 0 and `tx_ready` is 1.
- R2: The generated bit clock toggles after every 3 `mclk_en` ticks when `fast_bck`=1 (64fs) and after every 6 ticks when `fast_bck`=0 (32fs). A frame has 64 or 32 bit periods. `out_lrck` is low for the left half, high for the right half, and changes only in the cycle where `out_bck` falls.
- R3: Each output word is sent MSB first, starting one bit period after the frame-clock edge of its channel. `wlen_sel` 0, 1 and 2/3 select 16, 18 and 20 bits. `fast_bck`=0 forces 16 bits. Slot bits after the word are 0. `out_sd` changes only when `out_bck` falls.
- R4: `tx_ready` is high exactly when the holding register is empty. A set is accepted on a cycle with `tx_valid` and `tx_ready` both high, and `tx_ready` is low on the next cycle.
- R5: A held set is moved into the serializer at the start of the left MSB bit period. `tx_load` pulses for one cycle at that point, while `out_lrck` is low. If nothing is held at that point, the whole frame carries zeros.
- R6: `tx_words` packs {line2 right, line2 left, line1 right, line1 left, line0 right, line0 left}, 20 bits each, line0 left in bits 19:0. Each line carries its own pair on `out_sd[k]` under the shared clocks.
- R7: A receive port samples data on the rising bit-clock edge. It returns the top `wlen` bits of each word left-aligned in 20 bits, with the lower bits 0.
- R8: After the right word of a frame whose left word was also captured, the port pulses `rx_frame` for one cycle and sets `rx_valid`. Port p occupies bit p-1 of `rx_valid`/`rx_ready`/`rx_frame` and bits 20(p-1) upward of `rx_left`/`rx_right`.
- R9: `rx_valid` stays high and the pair stays unchanged until a cycle with `rx_ready` high, unless a newer complete pair replaces it.
- R10: With `mode_master`=1, port 1 uses the generated clocks, `p1_clk_oe`=1 and `p1_bck_o`/`p1_lrck_o` follow `out_bck`/`out_lrck`. With `mode_master`=0, `p1_clk_oe`=0 and port 1 follows `p1_bck_i`/`p1_lrck_i`.
- R11: Port 2 always follows `p2_bck`/`p2_lrck`, whatever `mode_master` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclk_en | input | 1 | 384fs master-clock tick |
| mode_master | input | 1 | 1: port 1 is clock master |
| fast_bck | input | 1 | 1: 64fs bit clock, 0: 32fs |
| wlen_sel | input | 2 | Word length select |
| p1_bck_i | input | 1 | Port 1 bit clock in (slave) |
| p1_lrck_i | input | 1 | Port 1 frame clock in (slave) |
| p1_sd | input | 1 | Port 1 serial data |
| p1_bck_o | output | 1 | Port 1 bit clock out (master) |
| p1_lrck_o | output | 1 | Port 1 frame clock out (master) |
| p1_clk_oe | output | 1 | Port 1 clock pin drive enable |
| p2_bck | input | 1 | Port 2 bit clock |
| p2_lrck | input | 1 | Port 2 frame clock |
| p2_sd | input | 1 | Port 2 serial data |
| rx_valid | output | 2 | Pair available, per port |
| rx_ready | input | 2 | Pair consumed, per port |
| rx_frame | output | 2 | Frame-complete strobe, per port |
| rx_left | output | 40 | Left words, per port |
| rx_right | output | 40 | Right words, per port |
| tx_valid | input | 1 | Six-word set offered |
| tx_ready | output | 1 | Holding register empty |
| tx_words | input | 120 | Six output words |
| tx_load | output | 1 | Held set moved into the serializer |
| out_bck | output | 1 | Shared output bit clock |
| out_lrck | output | 1 | Shared output frame clock |
| out_sd | output | 3 | Output data lines |

## Verification
The assertions check, on every cycle, that the frame clock and data lines change only on a falling bit-clock edge and that transmit ready drops after an accept. They also check that loads land in the left half, that the frame strobe lasts one cycle, and that a waiting receive pair neither changes nor disappears without ready. Other behaviour can only be shown by the bench's scenarios, which loop the output lines back into both receive ports. These cover bit-clock period and frame length in each rate, word truncation and zero fill for each length, and the 16-bit 32fs case, where the LSB lands after the frame-clock edge. They also cover zero frames on underrun, overwrite of an unread pair, and which clock pins each port follows in master and slave modes.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int WORD_W = 20;

  // effective word length; the 16-slot rate cannot carry more than 16 bits
  function automatic logic [4:0] wlen_bits(input logic [1:0] sel, input logic fast);
    logic [4:0] r;
    if (!fast) r = 5'd16;
    else begin
      case (sel)
        2'd0:    r = 5'd16;
        2'd1:    r = 5'd18;
        default: r = 5'd20;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/asp_sync.sv
module asp_sync #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/asp_rx.sv
module asp_rx import asp_pkg::*; #(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bck,
  input  logic         lrck,
  input  logic         sd,
  input  logic [4:0]   wlen,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] left,
  output logic [W-1:0] right,
  output logic         frame
);
  logic         bck_p, lr_q, ch_q, got_q, valid_q, frame_q;
  logic [4:0]   cnt_q;
  logic [W-1:0] sh_q, ltmp_q, left_q, right_q;

  logic         rise, edge0, take, done, pair_done;
  logic [W-1:0] sh_n, aligned;

  always_comb begin
    rise      = bck && !bck_p;
    edge0     = (lrck != lr_q);
    take      = rise && (cnt_q < wlen);
    sh_n      = {sh_q[W-2:0], sd};
    done      = take && ((cnt_q + 5'd1) == wlen);
    aligned   = sh_n << (5'(W) - wlen);
    pair_done = done && ch_q && got_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_p   <= 1'b0;
      lr_q    <= 1'b0;
      ch_q    <= 1'b0;
      got_q   <= 1'b0;
      valid_q <= 1'b0;
      frame_q <= 1'b0;
      cnt_q   <= 5'd31;
      sh_q    <= '0;
      ltmp_q  <= '0;
      left_q  <= '0;
      right_q <= '0;
    end else begin
      bck_p   <= bck;
      frame_q <= 1'b0;
      if (rise) begin
        lr_q <= lrck;
        if (edge0) begin
          cnt_q <= 5'd0;
          ch_q  <= lrck;
        end else if (take) begin
          cnt_q <= cnt_q + 5'd1;
        end
      end
      if (take) sh_q <= sh_n;
      if (done && !ch_q) begin
        ltmp_q <= aligned;
        got_q  <= 1'b1;
      end
      if (done && ch_q) got_q <= 1'b0;
      if (pair_done) begin
        left_q  <= ltmp_q;
        right_q <= aligned;
        valid_q <= 1'b1;
        frame_q <= 1'b1;
      end else if (valid_q && ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid = valid_q;
  assign left  = left_q;
  assign right = right_q;
  assign frame = frame_q;

  assert_frame_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |=> !frame_q);
  assert_valid_needs_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid_q) |-> $past(ready));
  assert_pair_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> ($stable(left_q) && $stable(right_q)) || frame_q);
endmodule

// File: rtl/asp_tx.sv
module asp_tx import asp_pkg::*; #(
  parameter int W     = WORD_W,
  parameter int LINES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 fast,
  input  logic [4:0]           wlen,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*LINES*W-1:0] in_words,
  output logic                 load,
  output logic                 bck,
  output logic                 lrck,
  output logic [LINES-1:0]     sd
);
  localparam int NW = 2 * LINES;

  logic [2:0]       div_q;
  logic [5:0]       pos_q;
  logic             bck_q, lrck_q, load_q, full_q;
  logic [LINES-1:0] sd_q;
  logic [W-1:0]     hold_q [NW];
  logic [W-1:0]     shad_q [NW];

  logic [2:0]       half_m1;
  logic [5:0]       slot, last, pos_n, q_n, j_n;
  logic             ch_n, toggle, fall_now, new_frame, load_now;
  logic [LINES-1:0] sd_n;
  logic [W-1:0]     word;

  function automatic logic pick(input logic [W-1:0] w, input logic [5:0] j, input logic [4:0] n);
    logic r;
    r = 1'b0;
    for (int b = 0; b < W; b++)
      if ((6'(W - 1 - b) == j) && ({1'b0, n} > j)) r = w[b];
    return r;
  endfunction

  always_comb begin
    half_m1   = fast ? 3'd2 : 3'd5;
    slot      = fast ? 6'd32 : 6'd16;
    last      = fast ? 6'd63 : 6'd31;
    toggle    = tick && (div_q >= half_m1);
    fall_now  = toggle && bck_q;
    pos_n     = (pos_q >= last) ? 6'd0 : pos_q + 6'd1;
    q_n       = (pos_n == 6'd0) ? last : pos_n - 6'd1;
    ch_n      = (q_n >= slot);
    j_n       = ch_n ? q_n - slot : q_n;
    new_frame = (pos_n == 6'd1);
    load_now  = fall_now && new_frame && full_q;
    word      = '0;
    for (int k = 0; k < LINES; k++) begin
      if (new_frame) word = full_q ? hold_q[2*k] : '0;
      else           word = shad_q[2*k + int'(ch_n)];
      sd_n[k] = pick(word, j_n, wlen);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      pos_q  <= '0;
      bck_q  <= 1'b0;
      lrck_q <= 1'b0;
      load_q <= 1'b0;
      full_q <= 1'b0;
      sd_q   <= '0;
      for (int i = 0; i < NW; i++) begin
        hold_q[i] <= '0;
        shad_q[i] <= '0;
      end
    end else begin
      load_q <= load_now;
      if (tick) div_q <= toggle ? 3'd0 : div_q + 3'd1;
      if (toggle) bck_q <= ~bck_q;
      if (fall_now) begin
        pos_q  <= pos_n;
        lrck_q <= (pos_n >= slot);
        sd_q   <= sd_n;
      end
      if (in_valid && !full_q) begin
        for (int i = 0; i < NW; i++) hold_q[i] <= in_words[i*W +: W];
        full_q <= 1'b1;
      end else if (load_now) begin
        full_q <= 1'b0;
      end
      if (fall_now && new_frame)
        for (int i = 0; i < NW; i++) shad_q[i] <= full_q ? hold_q[i] : '0;
    end
  end

  assign in_ready = !full_q;
  assign load     = load_q;
  assign bck      = bck_q;
  assign lrck     = lrck_q;
  assign sd       = sd_q;

  assert_lrck_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lrck_q) |-> $fell(bck_q));
  assert_data_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd_q) |-> $fell(bck_q));
  assert_ready_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_load_in_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_q |-> !lrck_q);
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port import asp_pkg::*; #(
  parameter int W     = WORD_W,
  parameter int LINES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mclk_en,
  input  logic                 mode_master,
  input  logic                 fast_bck,
  input  logic [1:0]           wlen_sel,
  input  logic                 p1_bck_i,
  input  logic                 p1_lrck_i,
  input  logic                 p1_sd,
  output logic                 p1_bck_o,
  output logic                 p1_lrck_o,
  output logic                 p1_clk_oe,
  input  logic                 p2_bck,
  input  logic                 p2_lrck,
  input  logic                 p2_sd,
  output logic [1:0]           rx_valid,
  input  logic [1:0]           rx_ready,
  output logic [1:0]           rx_frame,
  output logic [2*W-1:0]       rx_left,
  output logic [2*W-1:0]       rx_right,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [2*LINES*W-1:0] tx_words,
  output logic                 tx_load,
  output logic                 out_bck,
  output logic                 out_lrck,
  output logic [LINES-1:0]     out_sd
);
  localparam int PORTS = 2;

  logic [4:0] wlen;
  logic [2:0] raw [PORTS];
  logic [2:0] syn [PORTS];

  assign wlen = wlen_bits(wlen_sel, fast_bck);

  asp_tx #(.W(W), .LINES(LINES)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(mclk_en), .fast(fast_bck), .wlen(wlen),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_words(tx_words),
    .load(tx_load), .bck(out_bck), .lrck(out_lrck), .sd(out_sd)
  );

  assign p1_bck_o  = out_bck;
  assign p1_lrck_o = out_lrck;
  assign p1_clk_oe = mode_master;

  assign raw[0] = {mode_master ? out_bck : p1_bck_i,
                   mode_master ? out_lrck : p1_lrck_i, p1_sd};
  assign raw[1] = {p2_bck, p2_lrck, p2_sd};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    asp_sync #(.N(3)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw[p]), .q(syn[p]));
    asp_rx #(.W(W)) u_rx (
      .clk(clk), .rst_n(rst_n),
      .bck(syn[p][2]), .lrck(syn[p][1]), .sd(syn[p][0]),
      .wlen(wlen), .ready(rx_ready[p]), .valid(rx_valid[p]),
      .left(rx_left[p*W +: W]), .right(rx_right[p*W +: W]), .frame(rx_frame[p])
    );
  end
endmodule

// File: tb/audio_serial_port_test.sv
module audio_serial_port_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         mclk_en = 1'b1, slow_tick = 1'b0;
  logic         mode_master = 1'b1, fast_bck = 1'b1;
  logic [1:0]   wlen_sel = 2'd2;
  logic         loop1_en = 1'b0, loop2_en = 1'b1;
  logic [1:0]   sel2 = 2'd1;
  logic         p1_bck_i, p1_lrck_i, p1_sd, p1_bck_o, p1_lrck_o, p1_clk_oe;
  logic         p2_bck, p2_lrck, p2_sd;
  logic [1:0]   rx_valid, rx_frame;
  logic [1:0]   rx_ready = 2'b00;
  logic [39:0]  rx_left, rx_right;
  logic         tx_valid = 1'b0, tx_ready, tx_load, out_bck, out_lrck;
  logic [119:0] tx_words = '0;
  logic [2:0]   out_sd;

  assign p1_bck_i  = loop1_en & out_bck;
  assign p1_lrck_i = loop1_en & out_lrck;
  assign p1_sd     = out_sd[0];
  assign p2_bck    = loop2_en & out_bck;
  assign p2_lrck   = loop2_en & out_lrck;
  assign p2_sd     = out_sd[sel2];

  audio_serial_port uut (.*);

  always @(negedge clk) mclk_en <= slow_tick ? ~mclk_en : 1'b1;

  int checks = 0, errors = 0, cyc = 0, frames0 = 0;
  bit finished = 1'b0;

  always @(negedge clk) if (rx_frame[0]) frames0++;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  typedef struct packed {
    logic fast; logic [1:0] wsel; logic [1:0] line2;
    logic [19:0] l0, r0, l1, r1, l2, r2;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b1, 2'd2, 2'd1, 20'hA5C3F, 20'h5A3C1, 20'h80001, 20'h7FFFE, 20'h13579, 20'h2468A},
    '{1'b1, 2'd1, 2'd2, 20'hFFFFF, 20'h12345, 20'h0F0F3, 20'hF0F0C, 20'hC0FFE, 20'h0BEEF},
    '{1'b1, 2'd0, 2'd1, 20'h9ABCD, 20'h6543F, 20'hFFFFF, 20'h0000F, 20'h55555, 20'hAAAAA},
    '{1'b0, 2'd2, 2'd2, 20'hFFFFF, 20'h8001F, 20'h3C3C3, 20'hC3C3C, 20'h7777F, 20'h0001F}
  };

  function automatic logic [19:0] expw(input logic [19:0] w, input int wl);
    logic [19:0] m;
    m = ~((20'd1 << (20 - wl)) - 20'd1);
    return w & m;
  endfunction

  task automatic send(input logic [119:0] w);
    @(negedge clk); tx_words = w; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk); tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R4 ready low after accept", 32'(tx_ready), 32'd0);
  endtask

  task automatic wait_load();
    int n = 0;
    @(negedge clk);
    while (!tx_load && n < 3000) begin @(negedge clk); n++; end
    chk(tx_load == 1'b1, "R5 load pulse seen", 32'(tx_load), 32'd1);
    chk(out_lrck == 1'b0, "R5 load in left half", 32'(out_lrck), 32'd0);
  endtask

  task automatic drain();
    @(negedge clk); rx_ready = 2'b11;
    @(negedge clk); rx_ready = 2'b00;
  endtask

  task automatic wait_valid(input logic [1:0] m);
    int n = 0;
    while ((rx_valid & m) != m && n < 3000) begin @(negedge clk); n++; end
    chk((rx_valid & m) == m, "R8 pair valid", 32'(rx_valid), 32'(m));
  endtask

  task automatic run_vec(input vec_t v);
    int wl;
    fast_bck = v.fast; wlen_sel = v.wsel; sel2 = v.line2;
    wl = !v.fast ? 16 : (v.wsel == 2'd0 ? 16 : (v.wsel == 2'd1 ? 18 : 20));
    repeat (900) @(negedge clk);
    send({v.r2, v.l2, v.r1, v.l1, v.r0, v.l0});
    wait_load();
    repeat (4) @(negedge clk);
    drain();
    wait_valid(2'b11);
    chk(rx_left[19:0] == expw(v.l0, wl), "R3 R7 line0 left", 32'(rx_left[19:0]), 32'(expw(v.l0, wl)));
    chk(rx_right[19:0] == expw(v.r0, wl), "R3 R7 line0 right", 32'(rx_right[19:0]), 32'(expw(v.r0, wl)));
    chk(rx_left[39:20] == expw(v.line2 == 2'd2 ? v.l2 : v.l1, wl), "R6 second line left",
        32'(rx_left[39:20]), 32'(expw(v.line2 == 2'd2 ? v.l2 : v.l1, wl)));
    chk(rx_right[39:20] == expw(v.line2 == 2'd2 ? v.r2 : v.r1, wl), "R6 second line right",
        32'(rx_right[39:20]), 32'(expw(v.line2 == 2'd2 ? v.r2 : v.r1, wl)));
    drain();
  endtask

  task automatic measure(output int per, output int bits);
    logic pb, pl;
    int n;
    do begin pb = out_bck; @(negedge clk); end while (!(out_bck && !pb));
    n = 0;
    do begin pb = out_bck; @(negedge clk); n++; end while (!(out_bck && !pb));
    per = n;
    do begin pl = out_lrck; @(negedge clk); end while (!(out_lrck && !pl));
    n = 0;
    do begin
      pl = out_lrck; pb = out_bck; @(negedge clk);
      if (out_bck && !pb) n++;
    end while (!(out_lrck && !pl));
    bits = n;
  endtask

  initial begin
    int per, bits, f0;
    logic pl;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    chk({out_bck, out_lrck, out_sd, tx_load} == 6'd0, "R1 outputs low in reset",
        32'({out_bck, out_lrck, out_sd, tx_load}), 32'd0);
    chk(tx_ready == 1'b1, "R1 ready in reset", 32'(tx_ready), 32'd1);
    chk({rx_valid, rx_frame} == 4'd0, "R1 rx idle in reset", 32'({rx_valid, rx_frame}), 32'd0);
    rst_n = 1'b1;

    // R2: bit clock period and frame length per rate
    repeat (900) @(negedge clk);
    measure(per, bits);
    chk(per == 6, "R2 64fs bit period", 32'(per), 32'd6);
    chk(bits == 64, "R2 64fs frame bits", 32'(bits), 32'd64);
    fast_bck = 1'b0; repeat (900) @(negedge clk);
    measure(per, bits);
    chk(per == 12, "R2 32fs bit period", 32'(per), 32'd12);
    chk(bits == 32, "R2 32fs frame bits", 32'(bits), 32'd32);
    fast_bck = 1'b1; slow_tick = 1'b1; repeat (900) @(negedge clk);
    measure(per, bits);
    chk(per == 12, "R2 half-rate tick period", 32'(per), 32'd12);
    slow_tick = 1'b0;

    // R10 master: clock pins driven from the shared clocks
    chk(p1_clk_oe == 1'b1, "R10 master oe", 32'(p1_clk_oe), 32'd1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (i % 5 == 0)
        chk({p1_bck_o, p1_lrck_o} == {out_bck, out_lrck}, "R10 master clocks out",
            32'({p1_bck_o, p1_lrck_o}), 32'({out_bck, out_lrck}));
    end

    // table walk (port 1 master, its clock pins held low)
    for (int i = 0; i < 4; i++) run_vec(VECS[i]);

    // R5 underrun: an unloaded frame carries zeros
    fast_bck = 1'b1; wlen_sel = 2'd2;
    do begin pl = out_lrck; @(negedge clk); end while (!(!out_lrck && pl));
    repeat (20) @(negedge clk);
    drain();
    wait_valid(2'b11);
    chk(rx_left == 40'd0 && rx_right == 40'd0, "R5 underrun zeros", 32'(rx_left[19:0]), 32'd0);
    drain();

    // R9 hold and overwrite
    sel2 = 2'd1;
    send({20'h0, 20'h0, 20'h0, 20'h0, 20'h22222, 20'h11111});
    wait_load(); repeat (4) @(negedge clk); drain();
    send({20'h0, 20'h0, 20'h0, 20'h0, 20'h44444, 20'h33333});
    wait_load(); repeat (8) @(negedge clk);
    chk(rx_valid[0] == 1'b1, "R9 valid held without ready", 32'(rx_valid[0]), 32'd1);
    chk(rx_left[19:0] == 20'h11111, "R9 unread pair kept", 32'(rx_left[19:0]), 32'h11111);
    f0 = frames0;
    for (int n = 0; n < 3000 && frames0 == f0; n++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(rx_left[19:0] == 20'h33333 && rx_right[19:0] == 20'h44444, "R9 overwrite by newer pair",
        32'(rx_left[19:0]), 32'h33333);
    drain();

    // R10 slave: port 1 follows its own pins
    mode_master = 1'b0; loop1_en = 1'b1;
    @(negedge clk);
    chk(p1_clk_oe == 1'b0, "R10 slave oe", 32'(p1_clk_oe), 32'd0);
    run_vec(VECS[0]);
    loop1_en = 1'b0; repeat (500) @(negedge clk); drain();
    repeat (1000) @(negedge clk);
    chk(rx_valid == 2'b10, "R10 slave without pin clocks", 32'(rx_valid), 32'b10);

    // R11: port 2 follows only its pins, even in master mode
    mode_master = 1'b1; loop2_en = 1'b0; repeat (500) @(negedge clk); drain();
    repeat (1000) @(negedge clk);
    chk(rx_valid == 2'b01, "R11 port 2 ignores master clocks", 32'(rx_valid), 32'b01);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule